// File: doc/BRIEF.md
# Host Bridge Configuration Access Port

This block gives a host processor indirect access to the configuration registers of a single host bridge that sits at bus 0, device 0, function 0. Software first writes a 32-bit target address into an address latch through one I/O port. It then reads or writes the selected 32-bit register through a group of four data ports, whose low two port bits pick the starting byte lane.

Behind the ports is a 256-byte register array. It holds fixed identity bytes, a small set of non-zero reset values, and zeroes elsewhere. Each time the latch selects this function, and again after every accepted data write, a 32-bit data window is reloaded with the four array bytes at the selected dword. Reads are served from that window, shifted to the port's byte lane and masked to the access size. When the latch names any other target, data reads return all ones and data writes are dropped. An access to any port outside the decoded group raises a one-cycle error flag and changes nothing.

The slave interface is synchronous. A strobe is sampled on a rising clock edge, and read data appears on `rd_data` after that same edge. `rd_data` then holds until the next accepted read.

Top module: `cfgp_bridge`

## Requirements
- R1: After reset, `rd_data` is 0, `cfg_err` is 0 and the address latch reads 0, which is a non-matching target.
- R2: The address latch at port 0xCF8 loads `wr_data` only on a write with `acc_size` = 4. Writes of any other size leave it unchanged. A read of 0xCF8 returns the full latch value.
- R3: The latch selects this function exactly when (latch & 0x80FFFF00) = 0x80000000, so bits 30..24 and 7..0 are don't-care. A latch write that does not match clears the data window.
- R4: A read of data port 0xCFC+k (k = 0..3) returns the window shifted right by 8*k bits, masked to 8 bits for `acc_size` 1, 16 bits for 2, and 32 bits for 4. Any other size code acts as 4.
- R5: A data-port read while the latch does not match returns 0xFFFFFFFF.
- R6: A data-port write at lane k while matching writes byte i of `wr_data` (least significant first) to array index (latch & 0xFC) + k + i. The number of bytes written is the smaller of the access size and 4 - k. A data write while not matching changes no array byte.
- R7: After an accepted data write, the next data read returns the updated bytes, with no further latch write needed.
- R8: The identity bytes read 0x00=0x86, 0x01=0x80, 0x02=0x37, 0x03=0x12 and 0x0B=0x06, and writes to them are discarded.
- R9: After reset, 0x04=0x06, 0x06=0x80, 0x07=0x02, 0x51=0x01, 0x53=0x80, 0x57=0x01 and 0x58=0x10. Every other non-identity byte is 0.
- R10: A read or write strobe at a port that is neither 0xCF8 nor 0xCFC..0xCFF sets `cfg_err` for exactly the next cycle. It leaves the latch, the window, the array and `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_addr | input | 16 | I/O port number of the access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| acc_size | input | 3 | Access size in bytes: 1, 2 or 4 |
| wr_data | input | 32 | Write data, byte 0 in bits 7..0 |
| rd_data | output | 32 | Read data, valid after the edge that sampled `rd_en` |
| cfg_err | output | 1 | One-cycle pulse after an access to an undecoded port |

## Verification
A corrupted address latch shows on the very next read of 0xCF8. It also shows as all-ones, or as the wrong register, on the next data read. A stale or misaligned data window, or a wrong byte-enable after a clipped write, shows as a wrong lane value on the first data read after the write. A lost read-only guard shows on any readback of dword 0 or dword 8. The random mix of latch writes, lane-offset writes and size-varied reads is checked against a bench array model, so a divergence is caught within one read of the access that caused it.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int unsigned REG_CNT   = 256;
    localparam int unsigned IDX_W     = $clog2(REG_CNT);
    localparam int unsigned BUS_BYTES = 4;
    localparam int unsigned BUS_W     = BUS_BYTES * 8;
    localparam int unsigned OFF_W     = $clog2(BUS_BYTES);
    localparam int unsigned SIZE_W    = 3;

    localparam logic [BUS_W-1:0] HIT_MASK  = 32'h80FF_FF00;
    localparam logic [BUS_W-1:0] HIT_VALUE = 32'h8000_0000;

    typedef enum logic [1:0] {
        PK_IDLE = 2'd0,
        PK_ADDR = 2'd1,
        PK_DATA = 2'd2,
        PK_BAD  = 2'd3
    } port_kind_e;

    typedef struct packed {
        logic [BUS_W-1:0] addr;
        logic [BUS_W-1:0] win;
        logic [BUS_W-1:0] rdat;
        logic             err;
    } cfgp_state_t;

    function automatic logic target_hit(input logic [BUS_W-1:0] a);
        return (a & HIT_MASK) == HIT_VALUE;
    endfunction

    function automatic logic fixed_byte(input logic [IDX_W-1:0] idx);
        return (idx == 8'h00) || (idx == 8'h01) || (idx == 8'h02) ||
               (idx == 8'h03) || (idx == 8'h0B);
    endfunction

    function automatic logic [7:0] reset_byte(input logic [IDX_W-1:0] idx);
        logic [7:0] v;
        case (idx)
            8'h00:   v = 8'h86;
            8'h01:   v = 8'h80;
            8'h02:   v = 8'h37;
            8'h03:   v = 8'h12;
            8'h0B:   v = 8'h06;
            8'h04:   v = 8'h06;
            8'h06:   v = 8'h80;
            8'h07:   v = 8'h02;
            8'h51:   v = 8'h01;
            8'h53:   v = 8'h80;
            8'h57:   v = 8'h01;
            8'h58:   v = 8'h10;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

    function automatic logic [SIZE_W-1:0] eff_bytes(input logic [SIZE_W-1:0] sz);
        logic [SIZE_W-1:0] n;
        case (sz)
            3'd1:    n = 3'd1;
            3'd2:    n = 3'd2;
            default: n = 3'd4;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode
    import cfgp_pkg::*;
#(
    parameter int unsigned          PORT_W    = 16,
    parameter logic [PORT_W-1:0]    ADDR_PORT = 16'h0CF8,
    parameter logic [PORT_W-1:0]    DATA_PORT = 16'h0CFC
) (
    input  logic [PORT_W-1:0] port_addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output port_kind_e        kind,
    output logic [OFF_W-1:0]  lane_off
);

    logic strobe;
    logic is_addr;
    logic is_data;

    assign strobe   = wr_en || rd_en;
    assign is_addr  = (port_addr == ADDR_PORT);
    assign is_data  = (port_addr[PORT_W-1:OFF_W] == DATA_PORT[PORT_W-1:OFF_W]);
    assign lane_off = port_addr[OFF_W-1:0];

    always_comb begin
        if (!strobe)      kind = PK_IDLE;
        else if (is_addr) kind = PK_ADDR;
        else if (is_data) kind = PK_DATA;
        else              kind = PK_BAD;
    end

endmodule

// File: rtl/cfgp_lanes.sv
module cfgp_lanes
    import cfgp_pkg::*;
(
    input  logic [OFF_W-1:0]     lane_off,
    input  logic [SIZE_W-1:0]    acc_size,
    input  logic [BUS_W-1:0]     wr_data,
    output logic [BUS_BYTES-1:0] byte_en,
    output logic [BUS_W-1:0]     lane_data,
    output logic [BUS_W-1:0]     rd_mask
);

    logic [SIZE_W-1:0] want;
    logic [SIZE_W-1:0] room;
    logic [SIZE_W-1:0] cnt;
    logic [SIZE_W-1:0] off_x;

    assign want  = eff_bytes(acc_size);
    assign off_x = {1'b0, lane_off};
    assign room  = 3'(BUS_BYTES) - off_x;
    assign cnt   = (want < room) ? want : room;

    for (genvar j = 0; j < BUS_BYTES; j++) begin : g_be
        assign byte_en[j] = (3'(j) >= off_x) && (3'(j) < (off_x + cnt));
    end

    assign lane_data = wr_data << {lane_off, 3'b000};

    always_comb begin
        case (want)
            3'd1:    rd_mask = 32'h0000_00FF;
            3'd2:    rd_mask = 32'h0000_FFFF;
            default: rd_mask = 32'hFFFF_FFFF;
        endcase
    end

endmodule

// File: rtl/cfgp_regfile.sv
module cfgp_regfile
    import cfgp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [IDX_W-1:0]     base,
    input  logic [BUS_BYTES-1:0] byte_en,
    input  logic [BUS_W-1:0]     lane_data,
    output logic [BUS_W-1:0]     word
);

    logic [7:0] mem_q [REG_CNT];
    logic [7:0] mem_d [REG_CNT];

    always_comb begin
        for (int i = 0; i < REG_CNT; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we) begin
            for (int j = 0; j < BUS_BYTES; j++) begin
                if (byte_en[j] && !fixed_byte({base[IDX_W-1:OFF_W], OFF_W'(j)})) begin
                    mem_d[{base[IDX_W-1:OFF_W], OFF_W'(j)}] = lane_data[8*j +: 8];
                end
            end
        end
    end

    // post-write view of the addressed dword
    always_comb begin
        for (int j = 0; j < BUS_BYTES; j++) begin
            word[8*j +: 8] = mem_d[{base[IDX_W-1:OFF_W], OFF_W'(j)}];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_CNT; i++) begin
                mem_q[i] <= reset_byte(IDX_W'(i));
            end
        end else begin
            for (int i = 0; i < REG_CNT; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

endmodule

// File: rtl/cfgp_bridge.sv
module cfgp_bridge
    import cfgp_pkg::*;
#(
    parameter int unsigned       PORT_W    = 16,
    parameter logic [PORT_W-1:0] ADDR_PORT = 16'h0CF8,
    parameter logic [PORT_W-1:0] DATA_PORT = 16'h0CFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [2:0]        acc_size,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic              cfg_err
);

    cfgp_state_t st_q, st_d;

    port_kind_e           kind;
    logic [OFF_W-1:0]     lane_off;
    logic [BUS_BYTES-1:0] byte_en;
    logic [BUS_W-1:0]     lane_data;
    logic [BUS_W-1:0]     rd_mask;
    logic [BUS_W-1:0]     rf_word;
    logic [IDX_W-1:0]     rf_base;
    logic                 rf_we;
    logic                 hit_q;
    logic                 latch_wr;

    cfgp_decode #(
        .PORT_W    (PORT_W),
        .ADDR_PORT (ADDR_PORT),
        .DATA_PORT (DATA_PORT)
    ) u_decode (
        .port_addr (port_addr),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .kind      (kind),
        .lane_off  (lane_off)
    );

    cfgp_lanes u_lanes (
        .lane_off  (lane_off),
        .acc_size  (acc_size),
        .wr_data   (wr_data),
        .byte_en   (byte_en),
        .lane_data (lane_data),
        .rd_mask   (rd_mask)
    );

    assign hit_q    = target_hit(st_q.addr);
    assign latch_wr = wr_en && (kind == PK_ADDR) && (acc_size == 3'd4);
    assign rf_we    = wr_en && (kind == PK_DATA) && hit_q;
    assign rf_base  = latch_wr ? wr_data[IDX_W-1:0] : st_q.addr[IDX_W-1:0];

    cfgp_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (rf_we),
        .base      (rf_base),
        .byte_en   (byte_en),
        .lane_data (lane_data),
        .word      (rf_word)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        case (kind)
            PK_ADDR: begin
                if (latch_wr) begin
                    st_d.addr = wr_data;
                    st_d.win  = target_hit(wr_data) ? rf_word : '0;
                end
                if (rd_en) begin
                    st_d.rdat = st_q.addr;
                end
            end
            PK_DATA: begin
                if (rf_we) begin
                    st_d.win = rf_word;
                end
                if (rd_en) begin
                    st_d.rdat = hit_q ? ((st_q.win >> {lane_off, 3'b000}) & rd_mask) : '1;
                end
            end
            PK_BAD: begin
                st_d.err = 1'b1;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rdat;
    assign cfg_err = st_q.err;

endmodule

// File: rtl/cfgp_bridge_chk.sv
module cfgp_bridge_chk
    import cfgp_pkg::*;
#(
    parameter int unsigned       PORT_W    = 16,
    parameter logic [PORT_W-1:0] ADDR_PORT = 16'h0CF8,
    parameter logic [PORT_W-1:0] DATA_PORT = 16'h0CFC
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PORT_W-1:0] port_addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [2:0]        acc_size,
    input logic [31:0]       wr_data,
    input logic [31:0]       rd_data,
    input logic              cfg_err,
    input logic [31:0]       addr_q,
    input logic [31:0]       win_q
);

    logic at_addr, at_data, at_bad, latch_go;

    assign at_addr  = (port_addr == ADDR_PORT);
    assign at_data  = (port_addr[PORT_W-1:2] == DATA_PORT[PORT_W-1:2]);
    assign at_bad   = (wr_en || rd_en) && !at_addr && !at_data;
    assign latch_go = wr_en && at_addr && (acc_size == 3'd4);

    // R2
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_go |=> $stable(addr_q));

    // R2
    latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_go |=> (addr_q == $past(wr_data)));

    // R3
    miss_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_go && !target_hit(wr_data)) |=> (win_q == 32'h0));

    // R5
    miss_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && at_data && !target_hit(addr_q)) |=> (rd_data == 32'hFFFF_FFFF));

    // R8
    id_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && port_addr == DATA_PORT && acc_size == 3'd1 &&
         (addr_q & 32'h80FF_FFFC) == 32'h8000_0000) |=> (rd_data == 32'h86));

    // R10
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(at_bad));

    // R10
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        at_bad |=> (cfg_err && $stable(addr_q) && $stable(win_q) && $stable(rd_data)));

endmodule

bind cfgp_bridge cfgp_bridge_chk #(
    .PORT_W    (PORT_W),
    .ADDR_PORT (ADDR_PORT),
    .DATA_PORT (DATA_PORT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_addr (port_addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .acc_size  (acc_size),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .cfg_err   (cfg_err),
    .addr_q    (st_q.addr),
    .win_q     (st_q.win)
);

// File: tb/cfgp_bridge_test.sv
`timescale 1ns/1ps
module cfgp_bridge_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] port_addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  acc_size = 3'd4;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        cfg_err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0]  m_arr [256];
    logic [31:0] m_addr;

    always #5 clk = ~clk;

    cfgp_bridge uut (
        .clk(clk), .rst_n(rst_n), .port_addr(port_addr), .wr_en(wr_en),
        .rd_en(rd_en), .acc_size(acc_size), .wr_data(wr_data),
        .rd_data(rd_data), .cfg_err(cfg_err)
    );

    function automatic bit m_hit(input logic [31:0] a);
        return (a & 32'h80FF_FF00) == 32'h8000_0000;
    endfunction

    function automatic int m_size(input logic [2:0] s);
        return (s == 3'd1) ? 1 : (s == 3'd2) ? 2 : 4;
    endfunction

    function automatic bit m_fixed(input int i);
        return (i <= 3) || (i == 11);
    endfunction

    function automatic logic [31:0] m_read(input int k, input logic [2:0] s);
        int b;
        logic [31:0] w, msk;
        if (!m_hit(m_addr)) return 32'hFFFF_FFFF;
        b = int'(m_addr[7:2]) * 4;
        w = {m_arr[b+3], m_arr[b+2], m_arr[b+1], m_arr[b]};
        msk = (m_size(s) == 1) ? 32'hFF : (m_size(s) == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
        return (w >> (8*k)) & msk;
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 256; i++) m_arr[i] = 8'h00;
        m_arr[0] = 8'h86; m_arr[1] = 8'h80; m_arr[2] = 8'h37; m_arr[3] = 8'h12;
        m_arr[11] = 8'h06;
        m_arr[4] = 8'h06; m_arr[6] = 8'h80; m_arr[7] = 8'h02;
        m_arr[8'h51] = 8'h01; m_arr[8'h53] = 8'h80;
        m_arr[8'h57] = 8'h01; m_arr[8'h58] = 8'h10;
        m_addr = 32'h0;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic access(input logic [15:0] p, input bit w, input bit r,
                          input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        port_addr = p; wr_en = w; rd_en = r; acc_size = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic set_latch(input logic [31:0] a);
        access(16'h0CF8, 1'b1, 1'b0, 3'd4, a);
        m_addr = a;
    endtask

    task automatic wr_data_port(input int k, input logic [2:0] s, input logic [31:0] d);
        access(16'h0CFC + 16'(k), 1'b1, 1'b0, s, d);
        if (m_hit(m_addr)) begin
            int n, b;
            n = m_size(s);
            if (n > 4 - k) n = 4 - k;
            b = int'(m_addr[7:2]) * 4 + k;
            for (int i = 0; i < n; i++)
                if (!m_fixed(b + i)) m_arr[b + i] = d[8*i +: 8];
        end
    endtask

    task automatic rd_check(input string req, input int k, input logic [2:0] s);
        access(16'h0CFC + 16'(k), 1'b0, 1'b1, s, 32'h0);
        check(req, rd_data, m_read(k, s));
    endtask

    task automatic latch_check(input string req);
        access(16'h0CF8, 1'b0, 1'b1, 3'd4, 32'h0);
        check(req, rd_data, m_addr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_sink;
        logic [31:0] keep;
        seed_sink = $urandom(32'd20231);
        m_reset();
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rd_data", rd_data, 32'h0);
        check("R1 cfg_err", {31'h0, cfg_err}, 32'h0);
        rst_n = 1'b1;
        latch_check("R1 latch");
        rd_check("R5 read before select", 0, 3'd4);

        // R8 / R9 identity and reset values
        set_latch(32'h8000_0000);
        rd_check("R8 dword0", 0, 3'd4);
        for (int a = 4; a < 256; a += 4) begin
            set_latch(32'h8000_0000 | 32'(a));
            rd_check("R9 reset dword", 0, 3'd4);
        end

        // R4 lanes and sizes
        set_latch(32'h8000_0000);
        for (int k = 0; k < 4; k++) begin
            rd_check("R4 lane size1", k, 3'd1);
            rd_check("R4 lane size2", k, 3'd2);
            rd_check("R4 lane size4", k, 3'd4);
            rd_check("R4 lane size code 3", k, 3'd3);
        end
        check("R4 explicit 0xCFE size2", m_read(2, 3'd2), 32'h0000_1237);

        // R8 read-only writes
        wr_data_port(0, 3'd4, 32'hFFFF_FFFF);
        rd_check("R8 dword0 after write", 0, 3'd4);
        check("R8 expect literal", m_read(0, 3'd4), 32'h1237_8086);
        set_latch(32'h8000_0008);
        wr_data_port(0, 3'd4, 32'hFFFF_FFFF);
        rd_check("R8 byte 0x0B kept", 0, 3'd4);
        check("R8 expect literal 0B", m_read(0, 3'd4), 32'h06FF_FFFF);

        // R6 clipping and R7 window reload
        set_latch(32'h8000_0060);
        wr_data_port(3, 3'd4, 32'hAABB_CCDD);
        rd_check("R6 clip lane3", 0, 3'd4);
        check("R6 expect literal", m_read(0, 3'd4), 32'hDD00_0000);
        wr_data_port(1, 3'd2, 32'h1234_5678);
        rd_check("R7 reload after size2", 0, 3'd4);

        // R3 don't-care bits and non-matching targets
        set_latch(32'hFF00_0064);
        rd_check("R3 bits 30..24 ignored", 0, 3'd4);
        set_latch(32'h8000_0800);
        rd_check("R5 other device", 0, 3'd4);
        wr_data_port(0, 3'd4, 32'hDEAD_BEEF);
        set_latch(32'h0000_0000);
        rd_check("R5 enable clear", 1, 3'd1);
        set_latch(32'h8000_0000);
        rd_check("R6 unmatched write dropped", 0, 3'd4);

        // R2 non-dword latch writes ignored
        access(16'h0CF8, 1'b1, 1'b0, 3'd2, 32'h8000_0050);
        latch_check("R2 size2 ignored");
        access(16'h0CF8, 1'b1, 1'b0, 3'd1, 32'h8000_0050);
        latch_check("R2 size1 ignored");

        // R10 undecoded port
        keep = rd_data;
        @(negedge clk);
        port_addr = 16'h0CF9; wr_en = 1'b1; acc_size = 3'd4; wr_data = 32'h8000_0004;
        @(negedge clk);
        wr_en = 1'b0;
        check("R10 err pulse", {31'h0, cfg_err}, 32'h1);
        check("R10 rd_data held", rd_data, keep);
        @(negedge clk);
        check("R10 err clears", {31'h0, cfg_err}, 32'h0);
        access(16'h0CFB, 1'b0, 1'b1, 3'd4, 32'h0);
        check("R10 rd_data held on read", rd_data, keep);
        latch_check("R10 latch unchanged");
        rd_check("R10 window unchanged", 0, 3'd4);

        // random mix
        for (int it = 0; it < 600; it++) begin
            int op, k;
            logic [2:0] s;
            op = int'($urandom_range(0, 9));
            k  = int'($urandom_range(0, 3));
            case ($urandom_range(0, 5))
                0, 1:    s = 3'd1;
                2, 3:    s = 3'd2;
                4:       s = 3'd4;
                default: s = 3'(($urandom_range(0, 1) == 0) ? 0 : 3);
            endcase
            if (op < 2) begin
                logic [31:0] a;
                a = {1'b1, 7'($urandom), 16'h0, 8'($urandom)};
                if ($urandom_range(0, 4) == 0) a = a ^ (32'h1 << $urandom_range(8, 31));
                set_latch(a);
            end else if (op < 5) begin
                wr_data_port(k, s, $urandom);
            end else if (op < 9) begin
                rd_check("R4 R6 R7 random read", k, s);
            end else begin
                latch_check("R2 random latch read");
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule